// File: doc/BRIEF.md
# Window Watchdog Supervisor FSM

This block watches a host controller through a trigger that has to arrive inside a timed window. A conditioning front end ahead of it supplies the debounced mode level, the debounced trigger level, and three one-cycle strobes: trigger accepted (the trigger has returned high), trigger error (the trigger stayed low too long) and wake edge. The block drives an active-low reset towards the host and an enable for peripherals that matter for safety.

After power-up the host is held in reset. Each time the reset is released, the host has to answer with a low mode level within a handshake interval. It is then supervised in a short window, which has a disable phase and an enable phase. A high mode level moves supervision to a much longer window that suits sleep, and in that window a wake edge restarts the host. One reloadable down-counter times every interval, and each duration is a parameter.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst` is high, `rst_n_o` and `enable_o` are both 0.
- R2: Once `rst` is released, `rst_n_o` stays 0 for exactly T_PWRUP cycles, counting the cycle in which `rst` is released.
- R3: When the reset is released, the mode-switch interval begins and lasts at most T_MODESW cycles. A low `mode_lvl` during this interval moves the block to the short disable phase on the next edge. If `mode_lvl` stays high for the whole interval, a reset pulse follows.
- R4: Each reset pulse holds `rst_n_o` at 0 for exactly T_RSTOUT cycles. The mode-switch interval then starts again.
- R5: The short window is a disable phase of T_SDIS cycles followed by an enable phase of T_SEN cycles. If no trigger is accepted by the end of the enable phase, a reset pulse starts.
- R6: A low `trg_lvl` in the short disable phase, or a `trg_err` strobe in the short enable phase, starts a reset pulse on the next edge.
- R7: A `trg_ok` strobe in the short enable phase starts a new short disable phase on the next edge.
- R8: A high `mode_lvl` in the short disable phase selects the long window: a disable phase of T_LDIS cycles, then an enable phase of T_LEN cycles. In the long window, `trg_ok` in the enable phase restarts the long disable phase. Any of the following starts a reset pulse: a low `trg_lvl` in the long disable phase, a `trg_err` strobe in the long enable phase, or the end of the long enable phase.
- R9: A low `mode_lvl` in the long disable phase returns the block to the short disable phase.
- R10: A `wake_edge` strobe in either long phase starts a reset pulse on the next edge, and the mode-switch interval follows that pulse. In the short window, `wake_edge` has no effect.
- R11: `enable_o` goes to 1 on the edge that accepts the GOOD_N-th consecutive short-window trigger. It is 0 during any reset and during the whole long window, and a sequence that is broken has to be built again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the block |
| rst | input | 1 | Synchronous active-high power-on reset |
| mode_lvl | input | 1 | Debounced mode level: 1 selects the long window, 0 selects the short window or completes the handshake |
| trg_lvl | input | 1 | Debounced trigger level, idle high |
| trg_ok | input | 1 | One-cycle strobe when the trigger returns high |
| trg_err | input | 1 | One-cycle strobe when the trigger has stayed low too long |
| wake_edge | input | 1 | One-cycle strobe on a detected wake-up edge |
| rst_n_o | output | 1 | Active-low reset to the host |
| enable_o | output | 1 | Peripheral enable |

## Verification
The state that is hardest to reach from the ports is the long enable phase with an accepted trigger in it. To get there, a mode handshake must complete, the mode level must rise during a short disable phase, and the whole long disable phase must pass with the trigger held high. Only after that can a trigger pulse restart the long disable phase. The bench shrinks every duration through the parameters, so that it can count each phase length exactly as the run length of `rst_n_o` at 1. It also builds the enable sequence and then breaks it by each route: a trigger error, the move to the long window, and a reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP = 3'd0,
        ST_MSW   = 3'd1,
        ST_SDIS  = 3'd2,
        ST_SEN   = 3'd3,
        ST_LDIS  = 3'd4,
        ST_LEN   = 3'd5,
        ST_ROUT  = 3'd6
    } wdg_state_e;

    function automatic logic in_short(wdg_state_e s);
        return (s == ST_SDIS) || (s == ST_SEN);
    endfunction

    function automatic logic holds_reset(wdg_state_e s);
        return (s == ST_PWRUP) || (s == ST_ROUT);
    endfunction

    function automatic int unsigned wdg_max(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdg_interval_timer.sv
module wdg_interval_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] rst_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= rst_val;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/wdg_trigger_tally.sv
module wdg_trigger_tally #(
    parameter int GOOD_N = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bump,
    output logic full
);
    localparam int TW = (GOOD_N < 2) ? 1 : $clog2(GOOD_N + 1);
    localparam logic [TW-1:0] TOP = TW'(GOOD_N);

    logic [TW-1:0] tally_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            tally_q <= '0;
        else if (bump && (tally_q != TOP))
            tally_q <= tally_q + 1'b1;
    end

    assign full = (tally_q == TOP);
endmodule

// File: rtl/wdg_seq_fsm.sv
module wdg_seq_fsm
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       expired,
    input  logic       mode_lvl,
    input  logic       trg_lvl,
    input  logic       trg_ok,
    input  logic       trg_err,
    input  logic       wake_edge,
    output wdg_state_e cur_state,
    output wdg_state_e nxt_state
);
    always_comb begin
        nxt_state = cur_state;
        case (cur_state)
            ST_PWRUP: if (expired) nxt_state = ST_MSW;
            ST_MSW: begin
                if (!mode_lvl)    nxt_state = ST_SDIS;
                else if (expired) nxt_state = ST_ROUT;
            end
            ST_SDIS: begin
                if (!trg_lvl)     nxt_state = ST_ROUT;
                else if (mode_lvl) nxt_state = ST_LDIS;
                else if (expired) nxt_state = ST_SEN;
            end
            ST_SEN: begin
                if (trg_err)      nxt_state = ST_ROUT;
                else if (trg_ok)  nxt_state = ST_SDIS;
                else if (expired) nxt_state = ST_ROUT;
            end
            ST_LDIS: begin
                if (!trg_lvl || wake_edge) nxt_state = ST_ROUT;
                else if (!mode_lvl) nxt_state = ST_SDIS;
                else if (expired)   nxt_state = ST_LEN;
            end
            ST_LEN: begin
                if (trg_err || wake_edge) nxt_state = ST_ROUT;
                else if (trg_ok)  nxt_state = ST_LDIS;
                else if (expired) nxt_state = ST_ROUT;
            end
            ST_ROUT: if (expired) nxt_state = ST_MSW;
            default: nxt_state = ST_PWRUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur_state <= ST_PWRUP;
        else     cur_state <= nxt_state;
    end
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdg_pkg::*;
#(
    parameter int unsigned T_PWRUP  = 201,
    parameter int unsigned T_MODESW = 1112,
    parameter int unsigned T_SDIS   = 130,
    parameter int unsigned T_SEN    = 124,
    parameter int unsigned T_LDIS   = 71970,
    parameter int unsigned T_LEN    = 30002,
    parameter int unsigned T_RSTOUT = 40,
    parameter int          GOOD_N   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_lvl,
    input  logic trg_lvl,
    input  logic trg_ok,
    input  logic trg_err,
    input  logic wake_edge,
    output logic rst_n_o,
    output logic enable_o
);
    localparam int unsigned MAX_T = wdg_max(wdg_max(wdg_max(T_PWRUP, T_MODESW),
                                            wdg_max(T_SDIS, T_SEN)),
                                            wdg_max(wdg_max(T_LDIS, T_LEN), T_RSTOUT));
    localparam int CNT_W = (MAX_T < 2) ? 1 : $clog2(MAX_T);
    localparam logic [CNT_W-1:0] LD_PWRUP = CNT_W'(T_PWRUP - 1);
    localparam logic [CNT_W-1:0] LD_MSW   = CNT_W'(T_MODESW - 1);
    localparam logic [CNT_W-1:0] LD_SDIS  = CNT_W'(T_SDIS - 1);
    localparam logic [CNT_W-1:0] LD_SEN   = CNT_W'(T_SEN - 1);
    localparam logic [CNT_W-1:0] LD_LDIS  = CNT_W'(T_LDIS - 1);
    localparam logic [CNT_W-1:0] LD_LEN   = CNT_W'(T_LEN - 1);
    localparam logic [CNT_W-1:0] LD_ROUT  = CNT_W'(T_RSTOUT - 1);

    wdg_state_e       cur_state;
    wdg_state_e       nxt_state;
    logic             expired;
    logic             tmr_load;
    logic [CNT_W-1:0] load_val;
    logic             tally_full;
    logic             trig_accepted;

    wdg_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .expired   (expired),
        .mode_lvl  (mode_lvl),
        .trg_lvl   (trg_lvl),
        .trg_ok    (trg_ok),
        .trg_err   (trg_err),
        .wake_edge (wake_edge),
        .cur_state (cur_state),
        .nxt_state (nxt_state)
    );

    // Every state change reloads the shared counter with the new interval.
    assign tmr_load = (nxt_state != cur_state);

    always_comb begin
        case (nxt_state)
            ST_PWRUP: load_val = LD_PWRUP;
            ST_MSW:   load_val = LD_MSW;
            ST_SDIS:  load_val = LD_SDIS;
            ST_SEN:   load_val = LD_SEN;
            ST_LDIS:  load_val = LD_LDIS;
            ST_LEN:   load_val = LD_LEN;
            ST_ROUT:  load_val = LD_ROUT;
            default:  load_val = LD_PWRUP;
        endcase
    end

    wdg_interval_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (load_val),
        .rst_val  (LD_PWRUP),
        .expired  (expired)
    );

    assign trig_accepted = (cur_state == ST_SEN) && (nxt_state == ST_SDIS);

    wdg_trigger_tally #(.GOOD_N(GOOD_N)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .clear (!in_short(cur_state)),
        .bump  (trig_accepted),
        .full  (tally_full)
    );

    assign rst_n_o  = !holds_reset(cur_state);
    assign enable_o = tally_full && in_short(cur_state);
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk
    import wdg_pkg::*;
#(
    parameter int unsigned T_ROUT = 40
) (
    input logic       clk,
    input logic       rst,
    input logic       trg_lvl,
    input logic       trg_ok,
    input logic       trg_err,
    input logic       wake_edge,
    input logic       rst_n_o,
    input logic       enable_o,
    input wdg_state_e cur_state
);
    logic        rst_d;
    int unsigned rout_cnt;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst || cur_state != ST_ROUT) rout_cnt <= 0;
        else                             rout_cnt <= rout_cnt + 1;
    end

    always @(negedge clk) begin
        if (rst_d) assert_held_in_reset_R1: assert (!rst_n_o && !enable_o);
    end

    assert_rout_length_R4: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_MSW && $past(cur_state) == ST_ROUT) |-> (rout_cnt == T_ROUT));

    assert_early_trigger_R6: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_SDIS && !trg_lvl) |=> !rst_n_o);

    assert_trig_error_R6: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_SEN && trg_err) |=> !rst_n_o);

    assert_good_trigger_R7: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_SEN && trg_ok && !trg_err) |=> (cur_state == ST_SDIS));

    assert_wake_long_R10: assert property (@(posedge clk) disable iff (rst)
        (wake_edge && (cur_state == ST_LDIS || cur_state == ST_LEN)) |=> !rst_n_o);

    assert_enable_short_only_R11: assert property (@(posedge clk) disable iff (rst)
        enable_o |-> (rst_n_o && in_short(cur_state)));
endmodule

bind wdog_supervisor wdog_supervisor_chk #(.T_ROUT(T_RSTOUT)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .trg_lvl   (trg_lvl),
    .trg_ok    (trg_ok),
    .trg_err   (trg_err),
    .wake_edge (wake_edge),
    .rst_n_o   (rst_n_o),
    .enable_o  (enable_o),
    .cur_state (cur_state)
);

// File: tb/test_wdog_supervisor.sv
module test_wdog_supervisor;
    localparam int T_PWRUP = 5, T_MSW = 12, T_SDIS = 6, T_SEN = 5;
    localparam int T_LDIS = 20, T_LEN = 10, T_ROUT = 4;

    logic clk = 0, rst = 1, mode_lvl = 1, trg_lvl = 1, trg_ok = 0, trg_err = 0, wake_edge = 0;
    logic rst_n_o, enable_o;
    int checks = 0, fails = 0, n;
    bit done = 0;

    always #10 clk = ~clk;

    wdog_supervisor #(.T_PWRUP(T_PWRUP), .T_MODESW(T_MSW), .T_SDIS(T_SDIS), .T_SEN(T_SEN),
                      .T_LDIS(T_LDIS), .T_LEN(T_LEN), .T_RSTOUT(T_ROUT), .GOOD_N(3))
    i_wdog_supervisor (.clk(clk), .rst(rst), .mode_lvl(mode_lvl), .trg_lvl(trg_lvl),
        .trg_ok(trg_ok), .trg_err(trg_err), .wake_edge(wake_edge),
        .rst_n_o(rst_n_o), .enable_o(enable_o));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts negedges on which rst_n_o holds val, starting at the current one.
    task automatic measure(input logic val, output int cnt);
        cnt = 0;
        while (rst_n_o === val && cnt < 100000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic enter_short();
        mode_lvl = 0;
        @(negedge clk);
    endtask

    task automatic short_trigger();
        repeat (T_SDIS + 1) @(negedge clk);
        trg_lvl = 0;
        repeat (2) @(negedge clk);
        trg_lvl = 1; trg_ok = 1;
        @(negedge clk);
        trg_ok = 0;
    endtask

    task automatic enter_long();
        enter_short();
        mode_lvl = 1;
        @(negedge clk);
    endtask

    task automatic reset_pulse(input string req);
        measure(0, n); check(req, n, T_ROUT);
    endtask

    task automatic scen_powerup();
        repeat (3) @(negedge clk);
        check("R1 rst_n_o", rst_n_o, 0);
        check("R1 enable_o", enable_o, 0);
        rst = 0;
        measure(0, n); check("R2 powerup length", n, T_PWRUP);
    endtask

    task automatic scen_no_handshake();
        measure(1, n); check("R3 handshake timeout", n, T_MSW);
        reset_pulse("R4 pulse length");
        measure(1, n); check("R4 mode switch restarts", n, T_MSW);
        reset_pulse("R4 second pulse");
    endtask

    task automatic scen_no_trigger();
        enter_short();
        measure(1, n); check("R5 short window length", n, T_SDIS + T_SEN);
        reset_pulse("R5 pulse");
    endtask

    task automatic scen_enable();
        enter_short();
        short_trigger(); check("R11 enable after 1", enable_o, 0);
        short_trigger(); check("R11 enable after 2", enable_o, 0);
        short_trigger(); check("R11 enable after 3", enable_o, 1);
        check("R7 no reset after trigger", rst_n_o, 1);
        measure(1, n); check("R7 window restarted", n, T_SDIS + T_SEN);
        check("R11 cleared by reset", enable_o, 0);
        reset_pulse("R5 pulse after timeout");
    endtask

    task automatic scen_early();
        enter_short();
        short_trigger();
        repeat (2) @(negedge clk);
        trg_lvl = 0;
        @(negedge clk);
        check("R6 early trigger reset", rst_n_o, 0);
        trg_lvl = 1;
        reset_pulse("R6 pulse");
    endtask

    task automatic scen_trig_error();
        enter_short();
        repeat (3) short_trigger();
        check("R11 enable before error", enable_o, 1);
        repeat (T_SDIS + 1) @(negedge clk);
        trg_lvl = 0; trg_err = 1;
        @(negedge clk);
        trg_err = 0; trg_lvl = 1;
        check("R6 trigger error reset", rst_n_o, 0);
        check("R11 cleared by error", enable_o, 0);
        reset_pulse("R6 pulse");
        enter_short();
        short_trigger();
        check("R11 sequence rebuilt from zero", enable_o, 0);
        measure(1, n);
        reset_pulse("R5 pulse");
    endtask

    task automatic scen_long_timeout();
        enter_short();
        repeat (3) short_trigger();
        check("R11 enable before long", enable_o, 1);
        mode_lvl = 1;
        @(negedge clk);
        check("R11 enable off in long", enable_o, 0);
        measure(1, n); check("R8 long window length", n, T_LDIS + T_LEN);
        reset_pulse("R8 pulse");
    endtask

    task automatic scen_long_trigger();
        enter_long();
        repeat (T_LDIS + 1) @(negedge clk);
        trg_lvl = 0;
        @(negedge clk);
        trg_lvl = 1; trg_ok = 1;
        @(negedge clk);
        trg_ok = 0;
        check("R8 long trigger accepted", rst_n_o, 1);
        check("R11 enable off in long", enable_o, 0);
        measure(1, n); check("R8 long disable restarted", n, T_LDIS + T_LEN);
        reset_pulse("R8 pulse");
    endtask

    task automatic scen_long_early();
        enter_long();
        repeat (3) @(negedge clk);
        trg_lvl = 0;
        @(negedge clk);
        trg_lvl = 1;
        check("R8 trigger in long disable", rst_n_o, 0);
        reset_pulse("R8 pulse");
    endtask

    task automatic scen_wake();
        enter_long();
        repeat (3) @(negedge clk);
        wake_edge = 1;
        @(negedge clk);
        wake_edge = 0;
        check("R10 wake in long disable", rst_n_o, 0);
        reset_pulse("R10 pulse");
        measure(1, n); check("R10 mode switch after wake", n, T_MSW);
        reset_pulse("R4 pulse");
        enter_long();
        repeat (T_LDIS + 2) @(negedge clk);
        wake_edge = 1;
        @(negedge clk);
        wake_edge = 0;
        check("R10 wake in long enable", rst_n_o, 0);
        reset_pulse("R10 pulse");
    endtask

    task automatic scen_back_to_short();
        enter_long();
        repeat (3) @(negedge clk);
        mode_lvl = 0;
        @(negedge clk);
        measure(1, n); check("R9 back to short window", n, T_SDIS + T_SEN);
        reset_pulse("R9 pulse");
    endtask

    task automatic scen_wake_short();
        enter_short();
        repeat (2) @(negedge clk);
        wake_edge = 1;
        @(negedge clk);
        wake_edge = 0;
        check("R10 wake ignored in short", rst_n_o, 1);
        measure(1, n); check("R10 short window unchanged", n, T_SDIS + T_SEN - 3);
        reset_pulse("R5 pulse");
    endtask

    initial begin
        scen_powerup();
        scen_no_handshake();
        scen_no_trigger();
        scen_enable();
        scen_early();
        scen_trig_error();
        scen_long_timeout();
        scen_long_trigger();
        scen_long_early();
        scen_wake();
        scen_back_to_short();
        scen_wake_short();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule